// File: doc/BRIEF.md
# Key-Guarded GPIO Pad Controller

This block drives and samples up to 32 general-purpose pads through a small register window. Each pin has two mode bits, called mode-high and mode-low, which combine with that pin's output data bit to decide how the pad behaves. The pad can act as an input, as a push-pull output, as an output that only sinks to low, or as an output that only sources to high. Output data is never written as a whole word. Software changes it through a set register and a clear register, so a pin can be changed without a read-modify-write.

A keyed guard protects the mode bits. Mode writes take effect only while the guard is held. The guard is a two-state machine. In `LK_OPEN` it moves to `LK_HELD` when the lock register is written with the engage key in its low 16 bits. In `LK_HELD` it returns to `LK_OPEN` when the lock register is written with zero in those bits. Any other key value keeps the current state. Pad inputs cross into the clock domain through two flip-flop stages before software can read them.

The register interface is single-cycle. A write commits on the rising clock edge. Read data is a combinational function of the address.

Top module: `padctl_top`

## Requirements
- R1: After reset every mode bit, every data bit and the guard are clear. All `pad_oe` bits are 0, and reads of 0x04, 0x08, 0x0C and 0x80 return 0.
- R2: A write to 0x14 sets the output data bits where the write data has ones. A write to 0x18 clears those bits. Zero bits leave their pins unchanged, and neither write needs the guard.
- R3: The pad encoding, with {mode-high, mode-low} and data bit d, is:
  - 00: `pad_oe`=0.
  - 01: `pad_oe`=1 and `pad_out`=d.
  - 10: `pad_oe`=~d and `pad_out`=0.
  - 11: `pad_oe`=d and `pad_out`=1.
  - `pad_out` reads 0 whenever `pad_oe` is 0.
- R4: The mode writes are listed below. Each takes effect only while the guard is held. Otherwise it is dropped.
  - 0x08 loads mode-high.
  - 0x0C loads mode-low.
  - 0x50 clears the mode-high bits written as 1.
  - 0x54 sets the mode-low bits written as 1.
  - 0x58 clears the mode-low bits written as 1.
- R5: Lock register at 0x80. Writing bits[15:0]=0xD42F enters `LK_HELD`. Writing bits[15:0]=0x0000 enters `LK_OPEN`. Any other key leaves the state unchanged, and bits[31:16] of the write are ignored. A read returns 1 in bit 31 when held and 0 in every other bit.
- R6: Offset 0x04 returns the pad inputs after two register stages. A level present at rising edge k is readable after edge k+1.
- R7: Reads of 0x08 and 0x0C return the current mode-high and mode-low bits of every pin.
- R8: Reads of any other offset return 0. This includes the write-only offsets 0x14, 0x18, 0x50, 0x54 and 0x58.
- R9: With NPIN below 32, write bits at and above NPIN are ignored, and read bits at and above NPIN return 0 (bit 31 of the lock register excepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, commits on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | NPIN | Pad input levels |
| pad_out | output | NPIN | Pad drive value |
| pad_oe | output | NPIN | Pad drive enable |

## Verification
Two of the block's functions can act in the same cycle. The first is input sampling: the synchroniser keeps shifting in pad levels every cycle. The second is a read of 0x04 issued in that same cycle. The bench changes `pad_in` in the very cycle it reads the data-in offset, and compares the result against a queue of past pad values. The read must return the level from two edges earlier, never the new one. The same every-cycle comparison covers guard transitions, with a mode write sent in the cycle right after a key write, so that it lands on the newly entered state.

// File: rtl/padctl_pkg.sv
package padctl_pkg;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned KEY_W  = 16;

    localparam logic [ADDR_W-1:0] OFS_DIN   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MODE1 = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MODE0 = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_DSET  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DCLR  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_M1CLR = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_M0SET = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_M0CLR = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_LOCK  = 8'h80;

    localparam logic [KEY_W-1:0] KEY_ENGAGE = 16'hD42F;
    localparam logic [KEY_W-1:0] KEY_DROP   = 16'h0000;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        PM_INPUT    = 2'b00,
        PM_PUSHPULL = 2'b01,
        PM_SINK     = 2'b10,
        PM_SOURCE   = 2'b11
    } pad_mode_e;
endpackage

// File: rtl/padctl_lock.sv
module padctl_lock
    import padctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key,
    output logic             held
);
    lock_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_OPEN;
        else        st_q <= st_d;
    end

    // next state: OPEN --engage--> HELD, HELD --drop--> OPEN, else stay
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_OPEN: if (key_wr && key == KEY_ENGAGE) st_d = LK_HELD;
            LK_HELD: if (key_wr && key == KEY_DROP)   st_d = LK_OPEN;
        endcase
    end

    // output process
    always_comb held = (st_q == LK_HELD);

    AST_LOCK_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key == KEY_ENGAGE) |=> held); // R5
    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key == KEY_DROP) |=> !held); // R5
    AST_LOCK_OTHER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key != KEY_ENGAGE && key != KEY_DROP) |=> $stable(held)); // R5
endmodule

// File: rtl/padctl_sync.sv
module padctl_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= pad_i;
            s2_q <= s1_q;
        end
    end

    assign sync_o = s2_q;

    // cycles since reset, saturating at 2, used only to qualify the check
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               warm_q <= 2'd0;
        else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_o == $past(pad_i, 2))); // R6
endmodule

// File: rtl/padctl_encode.sv
module padctl_encode
    import padctl_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] mode_hi,
    input  logic [W-1:0] mode_lo,
    input  logic [W-1:0] dout,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pad_mode_e pm;
        assign pm = pad_mode_e'({mode_hi[i], mode_lo[i]});
        always_comb begin
            unique case (pm)
                PM_INPUT: begin
                    pad_oe[i]  = 1'b0;
                    pad_out[i] = 1'b0;
                end
                PM_PUSHPULL: begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = dout[i];
                end
                PM_SINK: begin
                    pad_oe[i]  = ~dout[i];
                    pad_out[i] = 1'b0;
                end
                PM_SOURCE: begin
                    pad_oe[i]  = dout[i];
                    pad_out[i] = dout[i];
                end
            endcase
        end
    end
endmodule

// File: rtl/padctl_top.sv
module padctl_top
    import padctl_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe
);
    logic [NPIN-1:0] mode_hi_q, mode_lo_q, dout_q, din_s, wr_pins;
    logic            lock_held, key_wr, mode_wr;

    assign wr_pins = bus_wdata[NPIN-1:0];
    assign key_wr  = bus_we && (bus_addr == OFS_LOCK);

    always_comb begin
        mode_wr = bus_we && (bus_addr inside {OFS_MODE1, OFS_MODE0,
                                              OFS_M1CLR, OFS_M0SET, OFS_M0CLR});
    end

    padctl_lock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_wr (key_wr),
        .key    (bus_wdata[KEY_W-1:0]),
        .held   (lock_held)
    );

    padctl_sync #(.W(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in),
        .sync_o (din_s)
    );

    padctl_encode #(.W(NPIN)) u_enc (
        .mode_hi (mode_hi_q),
        .mode_lo (mode_lo_q),
        .dout    (dout_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // output data: set/clear only, no guard
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == OFS_DSET) dout_q <= dout_q | wr_pins;
            if (bus_addr == OFS_DCLR) dout_q <= dout_q & ~wr_pins;
        end
    end

    // mode bits: guarded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_hi_q <= '0;
            mode_lo_q <= '0;
        end else if (mode_wr && lock_held) begin
            case (bus_addr)
                OFS_MODE1: mode_hi_q <= wr_pins;
                OFS_MODE0: mode_lo_q <= wr_pins;
                OFS_M1CLR: mode_hi_q <= mode_hi_q & ~wr_pins;
                OFS_M0SET: mode_lo_q <= mode_lo_q | wr_pins;
                OFS_M0CLR: mode_lo_q <= mode_lo_q & ~wr_pins;
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DIN:   bus_rdata[NPIN-1:0] = din_s;
            OFS_MODE1: bus_rdata[NPIN-1:0] = mode_hi_q;
            OFS_MODE0: bus_rdata[NPIN-1:0] = mode_lo_q;
            OFS_LOCK:  bus_rdata[DATA_W-1] = lock_held;
            default:   bus_rdata = '0;
        endcase
    end

    AST_MODE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !lock_held) |=> ($stable(mode_hi_q) && $stable(mode_lo_q))); // R4
    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DSET) |=> ((dout_q & $past(wr_pins)) == $past(wr_pins))); // R2
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DCLR) |=> ((dout_q & $past(wr_pins)) == '0)); // R2
    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~(mode_hi_q | mode_lo_q)) == '0)); // R3
    AST_LOCK_READ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_LOCK) |-> (bus_rdata[DATA_W-2:0] == '0)); // R5
endmodule

// File: tb/test_padctl_top.sv
module test_padctl_top;
    import padctl_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [7:0]  addr;
    logic        we;
    logic [31:0] wd;
    logic [31:0] pin;
    logic [31:0] rd_w, po_w, oe_w;
    logic [31:0] rd_n;
    logic [5:0]  po_n, oe_n;

    padctl_top #(.NPIN(32)) i_padctl_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
        .bus_rdata(rd_w), .pad_in(pin), .pad_out(po_w), .pad_oe(oe_w));

    padctl_top #(.NPIN(6)) i_padctl_top_narrow (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
        .bus_rdata(rd_n), .pad_in(pin[5:0]), .pad_out(po_n), .pad_oe(oe_n));

    // behavioural reference state
    logic [31:0] m_hi, m_lo, m_dat;
    bit          m_lk;
    logic [31:0] hist[$];
    int          nchk = 0, nfail = 0;
    string       ph = "R1";
    bit          done = 0;

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] din;
        din = (hist.size() == 2) ? hist[0] : 32'h0;
        case (a)
            8'h04:   return din;
            8'h08:   return m_hi;
            8'h0C:   return m_lo;
            8'h80:   return {m_lk, 31'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        case (a)
            8'h04:        return "R6 data-in";
            8'h08, 8'h0C: return "R7 mode read";
            8'h80:        return "R5 lock read";
            default:      return "R8 unmapped";
        endcase
    endfunction

    task automatic chk(input string fld, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", ph, fld, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] a, input bit w, input logic [31:0] d, input logic [31:0] p);
        logic [31:0] eo, ee, er;
        @(negedge clk);
        addr = a; we = w; wd = d; pin = p;
        #1;
        for (int i = 0; i < 32; i++) begin
            case ({m_hi[i], m_lo[i]})
                2'b00: begin ee[i] = 1'b0;      eo[i] = 1'b0;     end
                2'b01: begin ee[i] = 1'b1;      eo[i] = m_dat[i]; end
                2'b10: begin ee[i] = ~m_dat[i]; eo[i] = 1'b0;     end
                default: begin ee[i] = m_dat[i]; eo[i] = m_dat[i]; end
            endcase
        end
        er = exp_rd(a);
        chk(rd_tag(a), rd_w, er);
        chk("R3 pad_oe", oe_w, ee);
        chk("R3 pad_out", po_w, eo);
        chk("R9 narrow rdata", rd_n, (a == 8'h80) ? er : (er & 32'h3F));
        chk("R9 narrow pads", {20'h0, oe_n, po_n}, {20'h0, ee[5:0], eo[5:0]});
        @(posedge clk);
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_dat = 0; m_lk = 0;
            hist.delete();
        end else begin
            hist.push_back(p);
            if (hist.size() > 2) void'(hist.pop_front());
            if (w) begin
                case (a)
                    8'h14: m_dat = m_dat | d;
                    8'h18: m_dat = m_dat & ~d;
                    8'h08: if (m_lk) m_hi = d;
                    8'h0C: if (m_lk) m_lo = d;
                    8'h50: if (m_lk) m_hi = m_hi & ~d;
                    8'h54: if (m_lk) m_lo = m_lo | d;
                    8'h58: if (m_lk) m_lo = m_lo & ~d;
                    8'h80: begin
                        if (d[15:0] == 16'hD42F) m_lk = 1;
                        else if (d[15:0] == 16'h0000) m_lk = 0;
                    end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        logic [7:0] offs [10];
        offs = '{8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h50, 8'h54, 8'h58, 8'h80, 8'h3C};
        rst_n = 0; addr = 0; we = 0; wd = 0; pin = 0;
        m_hi = 0; m_lo = 0; m_dat = 0; m_lk = 0;

        // R1: reset state, also just after release
        ph = "R1";
        cyc(8'h08, 0, 0, 32'hFFFF_FFFF);
        cyc(8'h0C, 0, 0, 32'hFFFF_FFFF);
        rst_n = 1;
        cyc(8'h04, 0, 0, 32'h0);
        cyc(8'h80, 0, 0, 32'h0);
        cyc(8'h08, 0, 0, 32'h0);

        // R4: mode writes dropped while open
        ph = "R4";
        cyc(8'h0C, 1, 32'hFFFF_FFFF, 0);
        cyc(8'h54, 1, 32'hFFFF_FFFF, 0);
        cyc(8'h08, 1, 32'hFFFF_FFFF, 0);
        cyc(8'h0C, 0, 0, 0);
        cyc(8'h08, 0, 0, 0);

        // R5: wrong key, then engage with upper garbage
        ph = "R5";
        cyc(8'h80, 1, 32'h0000_1234, 0);
        cyc(8'h80, 0, 0, 0);
        cyc(8'h80, 1, 32'hABCD_D42F, 0);
        cyc(8'h80, 0, 0, 0);

        // R4/R7: modes loaded; write right after engage
        ph = "R7";
        cyc(8'h08, 1, 32'h0F0F_0F0F, 0);
        cyc(8'h0C, 1, 32'h3333_3333, 0);
        cyc(8'h08, 0, 0, 0);
        cyc(8'h0C, 0, 0, 0);

        // R2/R3: data set/clear seen through the pad encodings
        ph = "R2";
        cyc(8'h14, 1, 32'h5555_5555, 0);
        cyc(8'h14, 1, 32'h00FF_0000, 0);
        cyc(8'h18, 1, 32'h0000_FFFF, 0);
        cyc(8'h18, 1, 32'h0, 0);
        ph = "R3";
        cyc(8'h14, 1, 32'hFFFF_FFFF, 0);
        cyc(8'h18, 1, 32'hAAAA_AAAA, 0);
        cyc(8'h00, 0, 0, 0);

        // R5: other key holds, drop releases, then writes dropped
        ph = "R5";
        cyc(8'h80, 1, 32'h0000_0001, 0);
        cyc(8'h80, 0, 0, 0);
        cyc(8'h80, 1, 32'hFFFF_0000, 0);
        ph = "R4";
        cyc(8'h58, 1, 32'hFFFF_FFFF, 0);
        cyc(8'h50, 1, 32'hFFFF_FFFF, 0);
        cyc(8'h0C, 0, 0, 0);
        cyc(8'h80, 1, 32'h0000_D42F, 0);
        cyc(8'h50, 1, 32'h0000_000F, 0);
        cyc(8'h58, 1, 32'h0000_0030, 0);
        cyc(8'h54, 1, 32'h8000_0000, 0);

        // R6: pad changes in the same cycle as data-in reads
        ph = "R6";
        cyc(8'h04, 0, 0, 32'hDEAD_BEEF);
        cyc(8'h04, 0, 0, 32'h1234_5678);
        cyc(8'h04, 0, 0, 32'h0000_0000);
        cyc(8'h04, 0, 0, 32'hFFFF_FFFF);
        cyc(8'h04, 0, 0, 32'hFFFF_FFFF);

        // R8: unmapped and write-only offsets
        ph = "R8";
        foreach (offs[k]) cyc(offs[k] == 8'h04 ? 8'h10 : offs[k], 0, 0, 32'h0F0F_0F0F);
        cyc(8'hFC, 0, 0, 0);

        // mixed traffic, every cycle compared
        ph = "R4";
        for (int n = 0; n < 400; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            a = offs[$urandom_range(0, 9)];
            d = $urandom;
            if (a == 8'h80) d[15:0] = ($urandom_range(0, 2) == 0) ? 16'h0000 :
                                      ($urandom_range(0, 1) == 0) ? 16'hD42F : d[15:0];
            cyc(a, $urandom_range(0, 1) == 1, d, $urandom);
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end
endmodule